// File: doc/BRIEF.md
# Clock Generator Power-Up Sequencer

This block is the control machine that brings a clock synthesizer from power-off to running outputs. It watches a flag saying that the analog supply is valid, and an active-low platform power-good input. Once the supply is up, the power-good input must stay low for a qualification interval. The machine then takes a single snapshot of the three frequency-select straps and starts the oscillator. After a settling interval it enables the clock outputs.

The snapshot is taken only once per power cycle. From the strap sample onward the power-good input is not looked at. Changes on the straps or on power-good cannot disturb a running clock. Only removal of the analog supply returns the machine to power-off, which also clears the held selection. Both intervals are counted in reference-clock cycles and set by parameters. The defaults correspond to roughly 0.25 ms and 1.8 ms with a 14.318 MHz reference.

Top module: `clkgen_pwrup_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `seq_state` is 0 (power-off), and `vco_run`, `out_en` and `freq_sel` are all 0.
- R2: In power-off, the machine moves to the wait state (`seq_state` = 1) on the first clock edge at which `supply_ok` is high. While `supply_ok` is low, `pgood_n` has no effect.
- R3: In the wait state, the machine stays there for as long as `pgood_n` is high.
- R4: The machine enters the strap-sample state (`seq_state` = 2) exactly `QUAL_CYCLES` + 2 edges after `pgood_n` is driven low. The 2 edges cover the input synchronizer. If `pgood_n` was already low long enough to have passed the synchronizer, the machine enters strap-sample `QUAL_CYCLES` edges after entering the wait state.
- R5: If a high level of `pgood_n` reaches the machine during qualification, the count restarts from zero.
- R6: `freq_sel` takes `strap_in` (bit i to bit i) on the edge that ends the first cycle in strap-sample. After that it does not change until power-off.
- R7: The machine enters run (`seq_state` = 3) `SETTLE_CYCLES` edges after entering strap-sample. `out_en` is 1 only in run. `vco_run` is 1 in strap-sample and in run, and 0 in power-off and wait.
- R8: Once strap-sample is reached, changes on `pgood_n` or `strap_in` do not affect `seq_state`, `freq_sel` or the outputs.
- R9: From any state, `supply_ok` low causes the next edge to give `seq_state` = 0 with `vco_run` and `out_en` at 0. `freq_sel` is cleared one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Analog supply valid |
| pgood_n | input | 1 | Platform power-good, active low, asynchronous |
| strap_in | input | 3 | Frequency-select strap levels |
| vco_run | output | 1 | Oscillator enable |
| freq_sel | output | 3 | Latched frequency selection |
| out_en | output | 1 | Clock output enable |
| seq_state | output | 2 | Current state: 0 off, 1 wait, 2 sample, 3 run |

## Verification
The hardest situation to reach from the ports is a qualification that is broken partway and then restarted. Reaching it needs a high level on `pgood_n` that lasts long enough to pass the two-flop synchronizer. The bench holds `pgood_n` low for about half the interval, raises it for several cycles, and drops it again. It then checks that the strap-sample state arrives exactly the full interval plus the synchronizer latency after the second drop, and not after the first. Supply loss is applied in the wait, sample and run states. One case brings the supply back with power-good already low, so the count starts with no synchronizer latency.

// File: rtl/clkgen_pwrup_pkg.sv
package clkgen_pwrup_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;

  function automatic logic state_vco_on(input seq_state_e s);
    return (s == ST_SAMPLE) || (s == ST_RUN);
  endfunction

  function automatic logic state_outputs_on(input seq_state_e s);
    return s == ST_RUN;
  endfunction

  function automatic int unsigned counter_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/pg_sync2.sv
module pg_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RESET_VAL;
      q_sync <= RESET_VAL;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/seq_cycle_timer.sv
module seq_cycle_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/strap_hold.sv
module strap_hold #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          capture,
  input  logic [SW-1:0] d,
  output logic [SW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (clear)   q <= '0;
    else if (capture) q <= d;
  end
endmodule

// File: rtl/clkgen_pwrup_seq.sv
module clkgen_pwrup_seq
  import clkgen_pwrup_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES   = 3580,
  parameter int unsigned SETTLE_CYCLES = 25773,
  parameter int unsigned STRAP_W       = 3
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               supply_ok,
  input  logic               pgood_n,
  input  logic [STRAP_W-1:0] strap_in,
  output logic               vco_run,
  output logic [STRAP_W-1:0] freq_sel,
  output logic               out_en,
  output logic [1:0]         seq_state
);
  localparam int unsigned CW = counter_width(QUAL_CYCLES, SETTLE_CYCLES);
  localparam logic [CW-1:0] QUAL_LAST   = CW'(QUAL_CYCLES - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);

  seq_state_e state_q, state_d;
  logic       pgood_n_s;
  logic       pg_low;
  logic [CW-1:0] cnt;

  // named internal events
  logic qual_done;
  logic settle_done;
  logic strap_capture;
  logic timer_clr;
  logic timer_inc;

  pg_sync2 #(.RESET_VAL(1'b1)) u_pg_sync (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .d_async (pgood_n),
    .q_sync  (pgood_n_s)
  );

  assign pg_low = !pgood_n_s;

  seq_cycle_timer #(.CW(CW)) u_timer (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .clr   (timer_clr),
    .inc   (timer_inc),
    .count (cnt)
  );

  assign qual_done     = supply_ok && (state_q == ST_WAIT) && pg_low && (cnt == QUAL_LAST);
  assign settle_done   = supply_ok && (state_q == ST_SAMPLE) && (cnt == SETTLE_LAST);
  assign strap_capture = supply_ok && (state_q == ST_SAMPLE) && (cnt == '0);

  always_comb begin
    timer_inc = 1'b0;
    timer_clr = 1'b1;
    if (supply_ok && !qual_done && !settle_done) begin
      if (state_q == ST_WAIT && pg_low) begin
        timer_inc = 1'b1;
        timer_clr = 1'b0;
      end else if (state_q == ST_SAMPLE) begin
        timer_inc = 1'b1;
        timer_clr = 1'b0;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    if (!supply_ok) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    state_d = ST_WAIT;
        ST_WAIT:   if (qual_done)   state_d = ST_SAMPLE;
        ST_SAMPLE: if (settle_done) state_d = ST_RUN;
        ST_RUN:    state_d = ST_RUN;
        default:   state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  strap_hold #(.SW(STRAP_W)) u_strap (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .clear   (state_q == ST_OFF),
    .capture (strap_capture),
    .d       (strap_in),
    .q       (freq_sel)
  );

  assign vco_run   = state_vco_on(state_q);
  assign out_en    = state_outputs_on(state_q);
  assign seq_state = state_q;

endmodule

// File: rtl/clkgen_pwrup_seq_chk.sv
module clkgen_pwrup_seq_chk #(
  parameter int unsigned STRAP_W = 3
) (
  input logic               clk_ref,
  input logic               rst_n,
  input logic               supply_ok,
  input logic               vco_run,
  input logic [STRAP_W-1:0] freq_sel,
  input logic               out_en,
  input logic [1:0]         seq_state
);
  p_off_exit_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (seq_state == 2'd0 && supply_ok) |=> seq_state == 2'd1);

  p_sample_from_wait_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (seq_state == 2'd2 && $past(seq_state) != 2'd2) |-> $past(seq_state) == 2'd1);

  p_strap_stable_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (seq_state == 2'd3 && $past(seq_state) == 2'd3) |-> $stable(freq_sel));

  p_out_only_run_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    out_en |-> seq_state == 2'd3);

  p_vco_before_out_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(out_en) |-> (vco_run && $past(vco_run)));

  p_pg_ignored_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (seq_state[1] && supply_ok) |=> seq_state[1]);

  p_supply_loss_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !supply_ok |=> (seq_state == 2'd0 && !out_en && !vco_run));
endmodule

bind clkgen_pwrup_seq clkgen_pwrup_seq_chk #(.STRAP_W(STRAP_W)) u_chk (
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .vco_run   (vco_run),
  .freq_sel  (freq_sel),
  .out_en    (out_en),
  .seq_state (seq_state)
);

// File: tb/test_clkgen_pwrup_seq.sv
`timescale 1ns/1ps
module test_clkgen_pwrup_seq;
  localparam int unsigned Q = 12;
  localparam int unsigned S = 30;

  logic       clk_ref = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic       pgood_n = 1'b1;
  logic [2:0] strap_in = 3'b000;
  logic       vco_run, out_en;
  logic [2:0] freq_sel;
  logic [1:0] seq_state;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk_ref = ~clk_ref;

  clkgen_pwrup_seq #(.QUAL_CYCLES(Q), .SETTLE_CYCLES(S), .STRAP_W(3)) i_clkgen_pwrup_seq (
    .clk_ref (clk_ref), .rst_n (rst_n), .supply_ok (supply_ok), .pgood_n (pgood_n),
    .strap_in (strap_in), .vco_run (vco_run), .freq_sel (freq_sel),
    .out_en (out_en), .seq_state (seq_state)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic t_reset();
    step(1);
    chk("R1", "state in reset", seq_state, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1", "state", seq_state, 0);
    chk("R1", "vco_run", vco_run, 0);
    chk("R1", "out_en", out_en, 0);
    chk("R1", "freq_sel", freq_sel, 0);
  endtask

  task automatic t_power_on();
    pgood_n = 1'b0;
    step(5);
    chk("R2", "pgood ignored while off", seq_state, 0);
    pgood_n = 1'b1;
    step(3);
    supply_ok = 1'b1;
    step(1);
    chk("R2", "off to wait", seq_state, 1);
    step(20);
    chk("R3", "wait holds while pgood_n high", seq_state, 1);
    chk("R7", "vco off in wait", vco_run, 0);
  endtask

  task automatic t_qualify_restart();
    strap_in = 3'b101;
    pgood_n = 1'b0;
    step(Q / 2 + 2);
    pgood_n = 1'b1;
    step(4);
    chk("R5", "still waiting after interrupted low", seq_state, 1);
    pgood_n = 1'b0;
    step(Q + 1);
    chk("R5", "no early sample after restart", seq_state, 1);
    step(1);
    chk("R4", "sample entered after Q+2", seq_state, 2);
    chk("R7", "vco on in sample", vco_run, 1);
    chk("R7", "out_en off in sample", out_en, 0);
    step(1);
    chk("R6", "straps captured", freq_sel, 5);
    strap_in = 3'b010;
    for (int i = 0; i < S - 2; i++) begin
      pgood_n = ~pgood_n;
      step(1);
    end
    chk("R7", "still sampling at S-1", seq_state, 2);
    chk("R7", "out_en off at S-1", out_en, 0);
    step(1);
    chk("R7", "run entered after S", seq_state, 3);
    chk("R7", "out_en on in run", out_en, 1);
    chk("R8", "freq_sel unchanged by strap/pgood toggles", freq_sel, 5);
    for (int i = 0; i < 10; i++) begin
      pgood_n = ~pgood_n;
      step(1);
    end
    chk("R8", "run kept under pgood toggles", seq_state, 3);
    chk("R8", "freq_sel held in run", freq_sel, 5);
  endtask

  task automatic t_supply_loss_run();
    supply_ok = 1'b0;
    step(1);
    chk("R9", "off after supply loss in run", seq_state, 0);
    chk("R9", "out_en off", out_en, 0);
    chk("R9", "vco off", vco_run, 0);
    step(1);
    chk("R9", "freq_sel cleared", freq_sel, 0);
  endtask

  task automatic t_loss_wait_and_sample();
    pgood_n = 1'b0;
    step(3);
    supply_ok = 1'b1;
    step(1);
    chk("R2", "wait again", seq_state, 1);
    step(5);
    supply_ok = 1'b0;
    step(1);
    chk("R9", "off after loss in wait", seq_state, 0);
    supply_ok = 1'b1;
    step(1);
    chk("R2", "wait after supply return", seq_state, 1);
    step(Q - 1);
    chk("R4", "pgood pre-low: not yet sampling", seq_state, 1);
    step(1);
    chk("R4", "pgood pre-low: sample after Q", seq_state, 2);
    step(1);
    chk("R6", "new straps captured", freq_sel, 2);
    step(3);
    supply_ok = 1'b0;
    step(1);
    chk("R9", "off after loss in sample", seq_state, 0);
    step(1);
    chk("R9", "freq_sel cleared after sample loss", freq_sel, 0);
  endtask

  always @(posedge clk_ref) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_power_on();
    t_qualify_restart();
    t_supply_loss_run();
    t_loss_wait_and_sample();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule